// File: doc/BRIEF.md
# Link Rate and Lane Count Selector

This block chooses a serial link configuration (a line rate from a fixed two-step rate ladder and a lane count of 1, 2 or 4) that carries a requested payload rate. It first adds the 8b/10b coding overhead to the payload rate. It starts at the fastest ladder rate that both ends support. At each rate it uses as few lanes as the rule below allows, then as slow a rate as that lane count allows. It issues a one-cycle start strobe to an external training engine and waits for a pass or fail result. A failed attempt moves it one step down the ladder, where it picks the lanes and rate again. When the ladder runs out, it raises a give-up flag.

Along with each chosen configuration it also provides the two bytes a controller sends to the sink: the rate divided by the 27000 unit, and the lane count with an enhanced-framing flag. The block starts a selection on a request pulse. It holds the configuration after a pass, until the next request.

Top module: `link_cfg_selector`

## Requirements
- R1: After reset, cfg_rate, cfg_lanes, rate_code and lane_byte are zero, and train_start and give_up are low.
- R2: The requirement used in all comparisons is need = floor(payload_rate / 8) * 10, with the division truncating before the multiply.
- R3: The first attempt uses the highest ladder rate (ladder 270000 then 162000, terminated by 0) that is not above cap_rate.
- R4: At a ladder step, the lane count starts at cap_lanes and is halved while (lanes/2) * rate > need.
- R5: With the lane count fixed, the rate steps down the ladder while next_rate * lanes > need. The terminator counts as 0.
- R6: A failed training result moves one ladder step below the rate just tried. The lane count is then recomputed from cap_lanes, followed by a new attempt.
- R7: When no ladder rate remains (after failures, or because cap_rate is below 162000), give_up rises, no strobe is issued, and give_up stays high until the next request.
- R8: rate_code equals cfg_rate / 27000. lane_byte holds cfg_lanes in bits 4:0, zeros in bits 6:5, and bit 7 set when sink_enh was high at the request.
- R9: train_start is a single-cycle pulse, one per attempt. cfg_rate and cfg_lanes change only in a cycle in which train_start is high.
- R10: After a passing result, no further strobe is issued, give_up stays low and the configuration is held.
- R11: A request that arrives while a selection or an attempt is outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Pulse that starts a new selection |
| payload_rate | input | PAY_W | Required payload rate, kB/s |
| cap_rate | input | RATE_W | Highest rate supported by both ends, kB/s |
| cap_lanes | input | LANE_W | Largest lane count supported by both ends (1, 2 or 4) |
| sink_enh | input | 1 | Sink supports enhanced framing |
| train_done | input | 1 | Training result is valid this cycle |
| train_ok | input | 1 | Training result: 1 pass, 0 fail |
| cfg_rate | output | RATE_W | Chosen rate, kB/s |
| cfg_lanes | output | LANE_W | Chosen lane count |
| rate_code | output | 8 | Chosen rate in 27000 kB/s units |
| lane_byte | output | 8 | Lane count with enhanced-framing flag in bit 7 |
| train_start | output | 1 | One-cycle strobe that starts a training attempt |
| give_up | output | 1 | Ladder exhausted, no configuration found |

## Verification
A wrong ladder index or lane register shows up as a wrong rate or lane count in the cycle of the next strobe. This happens within a handful of cycles after the request or the fail result, because every selection step takes one clock. A corrupted sequencing state shows up in one of three ways: a strobe that nobody awaits, a strobe wider than one cycle, or give_up raised beside a strobe. The bench's per-clock monitor catches each of these on the clock where it happens. A wrong overhead or truncation rule shows up only at the exact rate boundaries, so those payload values are driven on purpose.

// File: rtl/lsel_pkg.sv
package lsel_pkg;

  // Number of real rates in the ladder; a zero terminator follows them.
  localparam int LADDER_LEN = 2;
  localparam int RATE_UNIT  = 27000;

  function automatic int unsigned ladder_rate(input int idx);
    case (idx)
      0:       return 270000;
      1:       return 162000;
      default: return 0;
    endcase
  endfunction

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SKIP,
    ST_LANES,
    ST_DROP,
    ST_ISSUE,
    ST_WAIT,
    ST_DONE,
    ST_GIVEUP
  } sel_state_t;

endpackage

// File: rtl/lsel_ladder.sv
module lsel_ladder #(
  parameter int RATE_W = 20,
  parameter int IDX_W  = 2,
  parameter int CODE_W = 8
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [RATE_W-1:0] cur_rate,
  output logic [RATE_W-1:0] nxt_rate,
  output logic [CODE_W-1:0] cur_code
);
  import lsel_pkg::*;

  localparam int DEPTH = 1 << IDX_W;

  logic [RATE_W-1:0] rate_tbl [DEPTH];
  logic [CODE_W-1:0] code_tbl [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    localparam int unsigned RV = ladder_rate(g);
    assign rate_tbl[g] = RATE_W'(RV);
    assign code_tbl[g] = CODE_W'(RV / RATE_UNIT);
  end

  logic [IDX_W-1:0] idx_nxt;
  assign idx_nxt  = idx + IDX_W'(1);
  assign cur_rate = rate_tbl[idx];
  assign cur_code = code_tbl[idx];
  assign nxt_rate = (idx_nxt == '0) ? '0 : rate_tbl[idx_nxt];

endmodule

// File: rtl/lsel_fit.sv
module lsel_fit #(
  parameter int RATE_W = 20,
  parameter int LANE_W = 3,
  parameter int NEED_W = 23,
  parameter int CMP_W  = 23
) (
  input  logic [NEED_W-1:0] need,
  input  logic [RATE_W-1:0] cur_rate,
  input  logic [RATE_W-1:0] nxt_rate,
  input  logic [LANE_W-1:0] lanes,
  output logic              halve_ok,
  output logic              drop_ok
);
  logic [CMP_W-1:0] half_bw;
  logic [CMP_W-1:0] next_bw;
  logic [CMP_W-1:0] need_x;

  assign need_x  = CMP_W'(need);
  assign half_bw = CMP_W'(lanes >> 1) * CMP_W'(cur_rate);
  assign next_bw = CMP_W'(lanes) * CMP_W'(nxt_rate);

  assign halve_ok = half_bw > need_x;
  assign drop_ok  = next_bw > need_x;

endmodule

// File: rtl/link_cfg_selector.sv
module link_cfg_selector #(
  parameter int PAY_W  = 22,
  parameter int RATE_W = 20,
  parameter int LANE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [PAY_W-1:0]  payload_rate,
  input  logic [RATE_W-1:0] cap_rate,
  input  logic [LANE_W-1:0] cap_lanes,
  input  logic              sink_enh,
  input  logic              train_done,
  input  logic              train_ok,
  output logic [RATE_W-1:0] cfg_rate,
  output logic [LANE_W-1:0] cfg_lanes,
  output logic [7:0]        rate_code,
  output logic [7:0]        lane_byte,
  output logic              train_start,
  output logic              give_up
);
  import lsel_pkg::*;

  localparam int IDX_W  = $clog2(LADDER_LEN + 2);
  localparam int NEED_W = PAY_W + 1;
  localparam int PROD_W = RATE_W + LANE_W;
  localparam int CMP_W  = (NEED_W > PROD_W) ? NEED_W : PROD_W;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LADDER_LEN);

  sel_state_t        state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [LANE_W-1:0] lanes_q;
  logic [NEED_W-1:0] need_q;
  logic [RATE_W-1:0] cap_rate_q;
  logic [LANE_W-1:0] cap_lanes_q;
  logic              enh_q;

  logic [RATE_W-1:0] cur_rate;
  logic [RATE_W-1:0] nxt_rate;
  logic [7:0]        cur_code;
  logic              halve_ok;
  logic              drop_ok;
  logic              accept;

  lsel_ladder #(
    .RATE_W (RATE_W),
    .IDX_W  (IDX_W),
    .CODE_W (8)
  ) ladder_i (
    .idx      (idx_q),
    .cur_rate (cur_rate),
    .nxt_rate (nxt_rate),
    .cur_code (cur_code)
  );

  lsel_fit #(
    .RATE_W (RATE_W),
    .LANE_W (LANE_W),
    .NEED_W (NEED_W),
    .CMP_W  (CMP_W)
  ) fit_i (
    .need     (need_q),
    .cur_rate (cur_rate),
    .nxt_rate (nxt_rate),
    .lanes    (lanes_q),
    .halve_ok (halve_ok),
    .drop_ok  (drop_ok)
  );

  assign accept = req_valid &&
                  (state_q == ST_IDLE || state_q == ST_DONE || state_q == ST_GIVEUP);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      idx_q       <= '0;
      lanes_q     <= '0;
      need_q      <= '0;
      cap_rate_q  <= '0;
      cap_lanes_q <= '0;
      enh_q       <= 1'b0;
      cfg_rate    <= '0;
      cfg_lanes   <= '0;
      rate_code   <= '0;
      lane_byte   <= '0;
      train_start <= 1'b0;
      give_up     <= 1'b0;
    end else begin
      train_start <= 1'b0;
      if (accept) begin
        need_q      <= NEED_W'(payload_rate >> 3) * NEED_W'(10);
        cap_rate_q  <= cap_rate;
        cap_lanes_q <= cap_lanes;
        enh_q       <= sink_enh;
        idx_q       <= '0;
        give_up     <= 1'b0;
        state_q     <= ST_SKIP;
      end else begin
        case (state_q)
          ST_SKIP: begin
            if (idx_q >= LAST_IDX || cur_rate == '0) begin
              give_up <= 1'b1;
              state_q <= ST_GIVEUP;
            end else if (cur_rate > cap_rate_q) begin
              idx_q <= idx_q + IDX_W'(1);
            end else begin
              lanes_q <= cap_lanes_q;
              state_q <= ST_LANES;
            end
          end
          ST_LANES: begin
            if (halve_ok) lanes_q <= lanes_q >> 1;
            else          state_q <= ST_DROP;
          end
          ST_DROP: begin
            if (drop_ok) idx_q <= idx_q + IDX_W'(1);
            else         state_q <= ST_ISSUE;
          end
          ST_ISSUE: begin
            cfg_rate    <= cur_rate;
            cfg_lanes   <= lanes_q;
            rate_code   <= cur_code;
            lane_byte   <= {enh_q, 2'b00, 5'(lanes_q)};
            train_start <= 1'b1;
            state_q     <= ST_WAIT;
          end
          ST_WAIT: begin
            if (train_done) begin
              if (train_ok) begin
                state_q <= ST_DONE;
              end else begin
                idx_q   <= idx_q + IDX_W'(1);
                state_q <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/link_cfg_selector_chk.sv
module link_cfg_selector_chk #(
  parameter int RATE_W = 20,
  parameter int LANE_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [RATE_W-1:0] cfg_rate,
  input logic [LANE_W-1:0] cfg_lanes,
  input logic [7:0]        rate_code,
  input logic [7:0]        lane_byte,
  input logic              train_start,
  input logic              give_up
);

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    train_start |=> !train_start); // R9

  AST_RATE_ONLY_ON_START: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_rate) |-> train_start); // R9

  AST_LANES_ONLY_ON_START: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_lanes) |-> train_start); // R9

  AST_GIVEUP_NO_START: assert property (@(posedge clk) disable iff (rst)
    give_up |-> !train_start); // R7

  AST_LANES_LEGAL: assert property (@(posedge clk) disable iff (rst)
    train_start |-> ($countones(cfg_lanes) == 1)); // R4

  AST_RATE_ON_LADDER: assert property (@(posedge clk) disable iff (rst)
    train_start |-> (cfg_rate == RATE_W'(270000) || cfg_rate == RATE_W'(162000))); // R3

  AST_CODE_MATCHES: assert property (@(posedge clk) disable iff (rst)
    train_start |-> (32'(rate_code) * 32'd27000 == 32'(cfg_rate))); // R8

  AST_BYTE_LANES: assert property (@(posedge clk) disable iff (rst)
    train_start |-> (lane_byte[4:0] == 5'(cfg_lanes) && lane_byte[6:5] == 2'b00)); // R8

endmodule

bind link_cfg_selector link_cfg_selector_chk #(
  .RATE_W (RATE_W),
  .LANE_W (LANE_W)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .cfg_rate    (cfg_rate),
  .cfg_lanes   (cfg_lanes),
  .rate_code   (rate_code),
  .lane_byte   (lane_byte),
  .train_start (train_start),
  .give_up     (give_up)
);

// File: tb/link_cfg_selector_tb_top.sv
module link_cfg_selector_tb_top;

  localparam int PAY_W  = 22;
  localparam int RATE_W = 20;
  localparam int LANE_W = 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic [PAY_W-1:0]  payload_rate = '0;
  logic [RATE_W-1:0] cap_rate = '0;
  logic [LANE_W-1:0] cap_lanes = '0;
  logic              sink_enh = 1'b0;
  logic              train_done = 1'b0;
  logic              train_ok = 1'b0;
  logic [RATE_W-1:0] cfg_rate;
  logic [LANE_W-1:0] cfg_lanes;
  logic [7:0]        rate_code;
  logic [7:0]        lane_byte;
  logic              train_start;
  logic              give_up;

  int checks = 0;
  int errors = 0;
  bit expect_win = 1'b0;

  int exp_rate  [4];
  int exp_lanes [4];
  int n_exp;

  always #2.5 clk = ~clk;

  link_cfg_selector #(
    .PAY_W  (PAY_W),
    .RATE_W (RATE_W),
    .LANE_W (LANE_W)
  ) dut_i (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .payload_rate (payload_rate),
    .cap_rate     (cap_rate),
    .cap_lanes    (cap_lanes),
    .sink_enh     (sink_enh),
    .train_done   (train_done),
    .train_ok     (train_ok),
    .cfg_rate     (cfg_rate),
    .cfg_lanes    (cfg_lanes),
    .rate_code    (rate_code),
    .lane_byte    (lane_byte),
    .train_start  (train_start),
    .give_up      (give_up)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Per-clock monitor: strobes only when one is awaited, never beside give-up.
  always @(negedge clk) begin
    if (!rst && train_start && !expect_win) begin
      errors++;
      $display("FAIL R9/R11 unexpected strobe actual=1 expected=0");
    end
    if (!rst && train_start && give_up) begin
      errors++;
      $display("FAIL R7 strobe with give_up actual=1 expected=0");
    end
  end

  // Behavioural reference: list of attempts when every attempt fails.
  task automatic model(input int pay, input int cap, input int lanes);
    int lad [4];
    int need, i, n;
    lad[0] = 270000; lad[1] = 162000; lad[2] = 0; lad[3] = 0;
    need = (pay / 8) * 10;
    n_exp = 0;
    i = 0;
    while (lad[i] != 0 && lad[i] > cap) i++;
    while (lad[i] != 0) begin
      n = lanes;
      while ((n / 2) * lad[i] > need) n = n / 2;
      while (lad[i+1] * n > need) i++;
      exp_rate[n_exp]  = lad[i];
      exp_lanes[n_exp] = n;
      n_exp++;
      i++;
    end
  endtask

  task automatic send_req(input int pay, input int cap, input int lanes, input bit enh);
    @(negedge clk);
    payload_rate = PAY_W'(pay);
    cap_rate     = RATE_W'(cap);
    cap_lanes    = LANE_W'(lanes);
    sink_enh     = enh;
    req_valid    = 1'b1;
    @(negedge clk);
    req_valid    = 1'b0;
  endtask

  task automatic wait_event();
    for (int c = 0; c < 300; c++) begin
      if (train_start || give_up) break;
      @(negedge clk);
    end
  endtask

  task automatic respond(input bit ok);
    train_done = 1'b1;
    train_ok   = ok;
    @(negedge clk);
    train_done = 1'b0;
    train_ok   = 1'b0;
  endtask

  task automatic run_case(input string tag, input int pay, input int cap,
                          input int lanes, input bit enh, input int nfail);
    int held_rate, held_lanes;
    model(pay, cap, lanes);
    expect_win = 1'b1;
    send_req(pay, cap, lanes, enh);
    for (int k = 0; k < n_exp; k++) begin
      wait_event();
      chk(train_start == 1'b1, {tag, " R9 strobe seen"}, train_start, 1);
      chk(cfg_rate == RATE_W'(exp_rate[k]), {tag, " R3/R4/R5/R6 rate"}, cfg_rate, exp_rate[k]);
      chk(cfg_lanes == LANE_W'(exp_lanes[k]), {tag, " R4/R5/R6 lanes"}, cfg_lanes, exp_lanes[k]);
      chk(rate_code == 8'(exp_rate[k] / 27000), {tag, " R8 rate code"}, rate_code, exp_rate[k] / 27000);
      chk(lane_byte == {enh, 2'b00, 5'(exp_lanes[k])}, {tag, " R8 lane byte"},
          lane_byte, {enh, 2'b00, 5'(exp_lanes[k])});
      @(negedge clk);
      chk(train_start == 1'b0, {tag, " R9 single-cycle strobe"}, train_start, 0);
      if (k < nfail) begin
        respond(1'b0);
      end else begin
        expect_win = 1'b0;
        held_rate  = cfg_rate;
        held_lanes = cfg_lanes;
        respond(1'b1);
        repeat (20) @(negedge clk);
        chk(cfg_rate == RATE_W'(held_rate) && cfg_lanes == LANE_W'(held_lanes),
            {tag, " R10 config held"}, cfg_rate, held_rate);
        chk(give_up == 1'b0, {tag, " R10 no give_up"}, give_up, 0);
        return;
      end
    end
    expect_win = 1'b0;
    wait_event();
    repeat (3) @(negedge clk);
    chk(give_up == 1'b1, {tag, " R7 give_up"}, give_up, 1);
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(cfg_rate == '0 && cfg_lanes == '0, "R1 config zero", cfg_rate, 0);
    chk(rate_code == '0 && lane_byte == '0, "R1 bytes zero", rate_code, 0);
    chk(train_start == 1'b0 && give_up == 1'b0, "R1 flags low", give_up, 0);

    run_case("wide",      1000000, 270000, 4, 1'b1, 0);  // R3 R4: 270000 x4
    run_case("narrow",    200000,  270000, 4, 1'b0, 0);  // R4: 270000 x1
    run_case("slow",      100000,  270000, 4, 1'b0, 0);  // R5: 162000 x1
    run_case("capped",    1000000, 200000, 2, 1'b1, 0);  // R3: start at 162000
    run_case("trunc_lo",  215999,  270000, 4, 1'b0, 0);  // R2: need 269990
    run_case("trunc_hi",  216000,  270000, 4, 1'b0, 0);  // R2: need 270000
    run_case("fallback",  1000000, 270000, 4, 1'b0, 1);  // R6
    run_case("exhaust",   1000000, 270000, 4, 1'b0, 2);  // R7
    // R7: new request clears give_up
    expect_win = 1'b1;
    send_req(200000, 270000, 4, 1'b0);
    chk(give_up == 1'b0, "R7 cleared by request", give_up, 0);
    wait_event();
    @(negedge clk);
    respond(1'b1);
    expect_win = 1'b0;
    run_case("too_slow",  50000,   100000, 4, 1'b0, 0);  // R7: no rate at all

    // R11: request during an outstanding attempt is ignored
    expect_win = 1'b1;
    send_req(1000000, 270000, 4, 1'b0);
    wait_event();
    @(negedge clk);
    expect_win = 1'b0;
    send_req(100000, 270000, 1, 1'b1);
    repeat (10) @(negedge clk);
    chk(cfg_rate == RATE_W'(270000) && cfg_lanes == LANE_W'(4), "R11 ignored request",
        cfg_lanes, 4);
    chk(lane_byte[7] == 1'b0, "R11 enh flag unchanged", lane_byte[7], 0);
    respond(1'b1);
    repeat (10) @(negedge clk);
    chk(give_up == 1'b0 && cfg_rate == RATE_W'(270000), "R11 R10 held after pass",
        cfg_rate, 270000);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule